// File: doc/BRIEF.md
# Mode-Selectable System Clock Divider Tree

This block produces the CPU, 66 MHz, PCI and IOAPIC clocks of a system clock set from one fast source clock. In the two running modes the source clock runs at twice the synthesizer VCO rate. It also routes the reference and 48 MHz clocks to their outputs. Every output has its own output-enable flag, which the pad drivers use as a tri-state control. A disabled output is also held low. Three select inputs choose the mode: a frequency select and a two-bit configuration select. An active-low spread enable is combined with the configuration select to give a two-bit spread request for the external PLL.

There are three kinds of mode. The fast mode gives a 133 MHz CPU clock and the slow mode gives a 100 MHz CPU clock. In the slow mode the 66 MHz clock is the VCO divided by 3. The source clock is twice the VCO rate, so every divider is an even count of source cycles and every output has a 50% duty cycle. The block can also put every output in Hi-Z for board test. In test mode the source clock is an external test clock and the outputs are fixed fractions of it.

A select change is taken only at the end of a frame. A frame is the least common period of all dividers, so no clock is cut short. The rising edges at the start of a frame come in a fixed order: CPU first, then the 66 MHz clock, then PCI and IOAPIC.

Top module: `clkgen_divtree`

## Requirements
- R1: While reset is asserted, every clock output, every output enable and the spread request are 0. After reset is released, the selects are captured at the first source edge.
- R2: In fast mode (frequency select 1, configuration select not 00), the periods in source cycles are: CPU 2, 66 MHz 4, PCI 8, IOAPIC 16. Each clock is high for the first half of its period. The frame is 16 source cycles long.
- R3: In slow mode (frequency select 0, configuration select not 00), the periods in source cycles are: CPU 4, 66 MHz 6, PCI 12, IOAPIC 24. This makes the 66 MHz clock one third of the VCO rate. The frame is 24 source cycles long.
- R4: Frequency select 0 with configuration select 00 drives all six output enables to 0 and all six clock outputs low.
- R5: Frequency select 1 with configuration select 00 is test mode, and all enables are 1. The reference output equals the source clock. CPU and 48 MHz are source/2, the 66 MHz clock is source/4, PCI is source/8 and IOAPIC is source/16.
- R6: Configuration select 10 drives the 48 MHz enable to 0 and holds the 48 MHz output low. All other outputs run as in their speed mode.
- R7: The spread request is 00 for no spread, 01 for center spread and 10 for down spread. With the spread enable low, configuration select 01 gives 01, and 10 or 11 gives 10. With the spread enable high, or with configuration select 00, the request is 00.
- R8: Frame cycle 0 is the first cycle after a boundary. CPU rises in frame cycle 0, the 66 MHz clock rises in cycle 1, and PCI and IOAPIC rise in cycle 2.
- R9: A select change is applied only after the last cycle of the current frame. Until then, all outputs keep following the old mode.
- R10: In the running modes, the reference output follows the reference input. When its enable is on, the 48 MHz output follows the 48 MHz input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock: twice the VCO rate, or the test clock in test mode |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock from the crystal oscillator |
| usb_clk_i | input | 1 | 48 MHz clock from its own PLL |
| fsel_i | input | 1 | Frequency select: 1 fast, 0 slow |
| sel_i | input | 2 | Configuration select |
| spread_ni | input | 1 | Spread enable, active low |
| cpu_clk_o | output | 1 | CPU clock |
| m66_clk_o | output | 1 | 66 MHz clock |
| pci_clk_o | output | 1 | PCI clock |
| apic_clk_o | output | 1 | IOAPIC clock |
| ref_clk_o | output | 1 | Reference clock output |
| usb_clk_o | output | 1 | 48 MHz clock output |
| cpu_oe_o | output | 1 | CPU output enable |
| m66_oe_o | output | 1 | 66 MHz output enable |
| pci_oe_o | output | 1 | PCI output enable |
| apic_oe_o | output | 1 | IOAPIC output enable |
| ref_oe_o | output | 1 | Reference output enable |
| usb_oe_o | output | 1 | 48 MHz output enable |
| spread_mode_o | output | 2 | Spread request to the PLL |

## Verification
A wrong frame counter or phase counter shows at the ports within one frame, as a mis-placed rising edge relative to the CPU clock. The bench predicts every output bit in every source cycle, so a single bad edge is reported in the cycle where it occurs. A configuration register that loads in the middle of a frame shows as a period change before the boundary. The selects are changed mid-frame to expose this. A wrong mode decode shows at once on the enables or the spread request.

// File: rtl/clkgen_divtree.sv
module clkgen_divtree #(
  parameter int CPU_HALF_FAST  = 1,
  parameter int M66_HALF_FAST  = 2,
  parameter int PCI_HALF_FAST  = 4,
  parameter int APIC_HALF_FAST = 8,
  parameter int CPU_HALF_SLOW  = 2,
  parameter int M66_HALF_SLOW  = 3,
  parameter int PCI_HALF_SLOW  = 6,
  parameter int APIC_HALF_SLOW = 12,
  parameter int M66_LAG        = 1,
  parameter int PCI_LAG        = 2,
  parameter int APIC_LAG       = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  input  logic       usb_clk_i,
  input  logic       fsel_i,
  input  logic [1:0] sel_i,
  input  logic       spread_ni,
  output logic       cpu_clk_o,
  output logic       m66_clk_o,
  output logic       pci_clk_o,
  output logic       apic_clk_o,
  output logic       ref_clk_o,
  output logic       usb_clk_o,
  output logic       cpu_oe_o,
  output logic       m66_oe_o,
  output logic       pci_oe_o,
  output logic       apic_oe_o,
  output logic       ref_oe_o,
  output logic       usb_oe_o,
  output logic [1:0] spread_mode_o
);

  localparam int FRAME_FAST = 2 * APIC_HALF_FAST;
  localparam int FRAME_SLOW = 2 * APIC_HALF_SLOW;
  localparam int FRAME_MAX  = (FRAME_FAST > FRAME_SLOW) ? FRAME_FAST : FRAME_SLOW;
  localparam int CW         = $clog2(FRAME_MAX + 1);
  localparam int NDIV       = 4;

  function automatic int half_of(input int idx, input logic fast);
    case (idx)
      0:       return fast ? CPU_HALF_FAST : CPU_HALF_SLOW;
      1:       return fast ? M66_HALF_FAST : M66_HALF_SLOW;
      2:       return fast ? PCI_HALF_FAST : PCI_HALF_SLOW;
      default: return fast ? APIC_HALF_FAST : APIC_HALF_SLOW;
    endcase
  endfunction

  function automatic int lag_of(input int idx);
    case (idx)
      0:       return 0;
      1:       return M66_LAG;
      2:       return PCI_LAG;
      default: return APIC_LAG;
    endcase
  endfunction

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_w;
  logic          at_bound;
  logic          cfg_fsel_q;
  logic [1:0]    cfg_sel_q;
  logic          cfg_spread_nq;
  logic [NDIV-1:0] div_w;

  assign last_w   = cfg_fsel_q ? CW'(FRAME_FAST - 1) : CW'(FRAME_SLOW - 1);
  assign at_bound = (cnt_q == last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= CW'(FRAME_SLOW - 1);
      cfg_fsel_q    <= 1'b0;
      cfg_sel_q     <= 2'b00;
      cfg_spread_nq <= 1'b1;
    end else if (at_bound) begin
      cnt_q         <= '0;
      cfg_fsel_q    <= fsel_i;
      cfg_sel_q     <= sel_i;
      cfg_spread_nq <= spread_ni;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    localparam int LAG = lag_of(g);
    int            h_cur;
    int            h_use;
    logic [CW-1:0] ph_q;
    logic [CW-1:0] ph_n;
    logic          out_q;

    assign h_cur = half_of(g, cfg_fsel_q);
    assign h_use = half_of(g, at_bound ? fsel_i : cfg_fsel_q);

    always_comb begin
      if (at_bound)
        ph_n = (LAG == 0) ? '0 : CW'(2 * h_use - LAG);
      else if (ph_q == CW'(2 * h_cur - 1))
        ph_n = '0;
      else
        ph_n = ph_q + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ph_q  <= '0;
        out_q <= 1'b0;
      end else begin
        ph_q  <= ph_n;
        out_q <= (int'(ph_n) < h_use);
      end
    end

    assign div_w[g] = out_q;
  end

  logic test_m, hiz_m, usb_off_m, run_oe;
  assign test_m    = cfg_fsel_q && (cfg_sel_q == 2'b00);
  assign hiz_m     = !cfg_fsel_q && (cfg_sel_q == 2'b00);
  assign usb_off_m = (cfg_sel_q == 2'b10);
  assign run_oe    = !hiz_m;

  assign cpu_oe_o  = run_oe;
  assign m66_oe_o  = run_oe;
  assign pci_oe_o  = run_oe;
  assign apic_oe_o = run_oe;
  assign ref_oe_o  = run_oe;
  assign usb_oe_o  = run_oe && !usb_off_m;

  assign cpu_clk_o  = cpu_oe_o  & div_w[0];
  assign m66_clk_o  = m66_oe_o  & div_w[1];
  assign pci_clk_o  = pci_oe_o  & div_w[2];
  assign apic_clk_o = apic_oe_o & div_w[3];
  assign ref_clk_o  = ref_oe_o  & (test_m ? clk_i : ref_clk_i);
  assign usb_clk_o  = usb_oe_o  & (test_m ? div_w[0] : usb_clk_i);

  assign spread_mode_o = cfg_spread_nq           ? 2'b00 :
                         (cfg_sel_q == 2'b01)    ? 2'b01 :
                         cfg_sel_q[1]            ? 2'b10 : 2'b00;

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_bound |=> $stable({cfg_fsel_q, cfg_sel_q, cfg_spread_nq}));

  assert_pci_after_m66_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_w[2]) |-> $past(div_w[1]));

  assert_apic_after_cpu_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_w[3]) |-> $past(div_w[0], 2));

  assert_quiet_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({cpu_oe_o, m66_oe_o, pci_oe_o, apic_oe_o, ref_oe_o, usb_oe_o} == 6'b0) |->
    ({cpu_clk_o, m66_clk_o, pci_clk_o, apic_clk_o, ref_clk_o, usb_clk_o} == 6'b0));

endmodule

// File: tb/clkgen_divtree_tb.sv
module clkgen_divtree_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       usb_in = 1'b0;
  logic       fsel = 1'b1;
  logic [1:0] sel = 2'b01;
  logic       spread_n = 1'b0;
  logic       cpu_c, m66_c, pci_c, apic_c, ref_c, usb_c;
  logic       cpu_e, m66_e, pci_e, apic_e, ref_e, usb_e;
  logic [1:0] spread;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  clkgen_divtree dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_in), .usb_clk_i(usb_in),
    .fsel_i(fsel), .sel_i(sel), .spread_ni(spread_n),
    .cpu_clk_o(cpu_c), .m66_clk_o(m66_c), .pci_clk_o(pci_c), .apic_clk_o(apic_c),
    .ref_clk_o(ref_c), .usb_clk_o(usb_c),
    .cpu_oe_o(cpu_e), .m66_oe_o(m66_e), .pci_oe_o(pci_e), .apic_oe_o(apic_e),
    .ref_oe_o(ref_e), .usb_oe_o(usb_e), .spread_mode_o(spread)
  );

  typedef struct {
    logic [13:0] v;
    string       tag;
  } item_t;

  item_t exp_q[$];

  // model state: frame cycle and captured selects
  int         m_k = 23;
  logic       m_fsel = 1'b0;
  logic [1:0] m_sel = 2'b00;
  logic       m_spn = 1'b1;

  function automatic bit div_hi(int k, int half, int lag);
    int p  = 2 * half;
    int ph = ((k - lag) % p + p) % p;
    return ph < half;
  endfunction

  function automatic logic [13:0] predict();
    logic [5:0] d;
    logic [5:0] e;
    logic [1:0] s;
    bit test = m_fsel && m_sel == 2'b00;
    bit hiz  = !m_fsel && m_sel == 2'b00;
    int hc = m_fsel ? 1 : 2;
    int hm = m_fsel ? 2 : 3;
    int hp = m_fsel ? 4 : 6;
    int ha = m_fsel ? 8 : 12;
    e = hiz ? 6'b0 : {1'b1, !(m_sel == 2'b10), 4'hF};
    d[0] = div_hi(m_k, hc, 0);
    d[1] = div_hi(m_k, hm, 1);
    d[2] = div_hi(m_k, hp, 2);
    d[3] = div_hi(m_k, ha, 2);
    d[4] = test ? d[0] : usb_in;
    d[5] = test ? 1'b1 : ref_in;
    d = d & e;
    s = m_spn ? 2'b00 : (m_sel == 2'b01) ? 2'b01 : m_sel[1] ? 2'b10 : 2'b00;
    return {s, e, d};
  endfunction

  // predictor: advances the model at each source edge and queues the expected vector
  always @(posedge clk) begin
    if (rst_n) begin
      item_t it;
      bit pending;
      if (m_k == (m_fsel ? 15 : 23)) begin
        m_k = 0; m_fsel = fsel; m_sel = sel; m_spn = spread_n;
      end else m_k = m_k + 1;
      pending = (fsel != m_fsel) || (sel != m_sel) || (spread_n != m_spn);
      it.v = predict();
      if (!m_fsel && m_sel == 2'b00)      it.tag = "R4";
      else if (m_sel == 2'b00)            it.tag = "R5 R7";
      else if (m_sel == 2'b10)            it.tag = m_fsel ? "R6 R2 R7 R8" : "R6 R3 R7 R8";
      else                                it.tag = m_fsel ? "R2 R7 R8 R10" : "R3 R7 R8 R10";
      if (pending) it.tag = {it.tag, " R9"};
      exp_q.push_back(it);
    end
  end

  // monitor: samples a quarter period after the edge
  always @(posedge clk) begin
    logic [13:0] act;
    #5;
    act = {spread, ref_e, usb_e, apic_e, pci_e, m66_e, cpu_e,
           ref_c, usb_c, apic_c, pci_c, m66_c, cpu_c};
    if (!rst_n) begin
      checks++;
      if (act !== 14'h0) begin
        fails++;
        $display("FAIL R1 reset state: actual %h expected %h", act, 14'h0);
      end
    end else if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (act !== it.v) begin
        fails++;
        $display("FAIL %s at %0t: actual %h expected %h", it.tag, $time, act, it.v);
      end
    end
  end

  task automatic apply(input logic f, input logic [1:0] s, input logic spn, input int n);
    @(negedge clk);
    fsel = f; sel = s; spread_n = spn;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_in = i[0];
      usb_in = i[1];
    end
  endtask

  initial begin
    // R1: reset with the reference input high must keep every output low
    ref_in = 1'b1;
    usb_in = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 2'b01, 1'b0, 40);   // R2 fast, center spread
    apply(1'b0, 2'b11, 1'b0, 60);   // R3 slow, down spread, mid-frame change R9
    apply(1'b0, 2'b10, 1'b1, 50);   // R6 slow, no spread
    apply(1'b0, 2'b00, 1'b0, 30);   // R4 Hi-Z
    apply(1'b1, 2'b00, 1'b0, 40);   // R5 test mode
    apply(1'b1, 2'b10, 1'b0, 40);   // R6 fast, down spread
    apply(1'b0, 2'b01, 1'b1, 50);   // R3 R10 slow, no spread
    apply(1'b1, 2'b11, 1'b1, 40);   // R2 R7 spread disabled
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R9 queue not drained: actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule